// File: doc/BRIEF.md
# Low-Power Entry and Wakeup Controller

This block moves a processor subsystem into a low-power mode and brings it back out. An 8-bit control register, written over a simple single-cycle register bus, holds a stop-mode enable and a 3-bit wakeup threshold. When the core reports that it has halted on a stop instruction, the block picks a target mode. The target is stop if the enable is set, otherwise the doze or wait mode named by a select input. It then drops the core clock enable.

While the subsystem sleeps, every interrupt source is judged combinationally against the threshold. In stop mode only fixed (external) sources count. In doze and wait, programmable sources also count, provided the source is enabled for low-power operation. A qualifying request raises an exit request, and the clock enable returns one cycle later. The interrupt itself is left untouched so the core can service it once clocked. The block returns to its running state when the core acknowledges the exit.

Top module: `lpwr_seq`

## Requirements
- R1: After reset the register reads 0x00, the clock enable is 1, the exit request is 0 and the mode output is 00.
- R2: A write while running stores bit 7 (stop enable) and bits 6:4 (threshold). Bits 3:0 always read 0, and the new value is visible on the read port one edge after the write.
- R3: A register write made while not running leaves the read value unchanged.
- R4: With the stop enable set, a stop status sampled while running sets the mode output to 11 at that edge, and the clock enable falls at the following edge.
- R5: With the stop enable clear, a stop status enters doze (mode 01) when the select is 01 or wait (mode 10) when the select is 10. For select 00 or 11 the block stays running, with clock enable 1 and mode 00.
- R6: A source can wake the block only if its 3-bit level is strictly greater than the threshold; a level equal to it does not wake.
- R7: In stop mode a programmable (non-fixed) source never wakes the block, even when unmasked, enabled for low power and above the threshold.
- R8: In doze or wait, a programmable source wakes only when its low-power enable flag is set, while a fixed source wakes without it.
- R9: A source whose unmasked flag is 0 never wakes the block.
- R10: The exit request rises at the first edge at which a qualifying request is seen in low-power state, and the clock enable returns one edge later. Both hold until the core acknowledge is sampled with the clock enable high, after which the exit request is 0 and the mode is 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running control clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| core_stop | input | 1 | Core status: stop instruction executed |
| mode_sel | input | 2 | Non-stop target: 01 doze, 10 wait, else none |
| core_ack | input | 1 | Core acknowledge of the exit request |
| irq_lvl | input | 3*NSRC | Per-source priority levels, source i at bits 3i+2:3i |
| irq_unmasked | input | NSRC | Per-source unmasked flag |
| irq_fixed | input | NSRC | Per-source fixed (external) flag |
| irq_lp_en | input | NSRC | Per-source enabled-in-low-power flag |
| clk_en_core | output | 1 | Core clock enable |
| exit_req | output | 1 | Request to leave low-power mode |
| lp_mode | output | 2 | Active mode: 00 run, 01 doze, 10 wait, 11 stop |

## Verification
Register writes show on the read port one edge after the strobe. A stop status changes the mode output one edge later and the clock enable two edges later. A qualifying wake raises the exit request one edge later and restores the clock enable at the second edge, and an acknowledge returns the mode to 00 one edge later. The driver records each expectation together with the cycle at which it falls due, counted in these edges. The monitor compares the outputs one nanosecond after the edge of that cycle, so that every result is sampled where it has settled.

// File: rtl/lpwr_pkg.sv
package lpwr_pkg;
   localparam int unsigned CTRL_W      = 8;
   localparam int unsigned THR_W       = 3;
   localparam int unsigned STOP_EN_POS = 7;
   localparam int unsigned THR_LSB     = 4;

   typedef enum logic [1:0] {
      ST_RUN   = 2'd0,
      ST_ENTER = 2'd1,
      ST_LOWP  = 2'd2,
      ST_EXIT  = 2'd3
   } lp_state_e;

   typedef enum logic [1:0] {
      MD_NONE = 2'b00,
      MD_DOZE = 2'b01,
      MD_WAIT = 2'b10,
      MD_STOP = 2'b11
   } lp_mode_e;
endpackage

// File: rtl/lpwr_ctrl_reg.sv
module lpwr_ctrl_reg
   import lpwr_pkg::*;
#(
   parameter int unsigned REG_W   = CTRL_W,
   parameter int unsigned LVL_W   = THR_W,
   parameter int unsigned EN_POS  = STOP_EN_POS,
   parameter int unsigned LVL_LSB = THR_LSB
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_allow,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wdata,
   output logic             stop_en,
   output logic [LVL_W-1:0] thr,
   output logic [REG_W-1:0] rdata
);
   localparam int unsigned LVL_MSB = LVL_LSB + LVL_W - 1;

   if (EN_POS >= REG_W || LVL_MSB >= REG_W || LVL_MSB >= EN_POS) begin : g_bad_layout
      $error("lpwr_ctrl_reg: field layout does not fit the register");
   end

   logic             en_q;
   logic [LVL_W-1:0] thr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q  <= 1'b0;
         thr_q <= '0;
      end else if (wr_en && wr_allow) begin
         en_q  <= wdata[EN_POS];
         thr_q <= wdata[LVL_MSB:LVL_LSB];
      end
   end

   always_comb begin
      rdata                   = '0;
      rdata[EN_POS]           = en_q;
      rdata[LVL_MSB:LVL_LSB]  = thr_q;
   end

   assign stop_en = en_q;
   assign thr     = thr_q;

   AST_HOLD_OUTSIDE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_allow |=> $stable(rdata)) else $error("register changed outside run"); // R3
endmodule

// File: rtl/lpwr_wake_qual.sv
module lpwr_wake_qual
   import lpwr_pkg::*;
#(
   parameter int unsigned NSRC  = 4,
   parameter int unsigned LVL_W = THR_W
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  lp_mode_e              mode,
   input  logic [LVL_W-1:0]      thr,
   input  logic [NSRC*LVL_W-1:0] src_lvl,
   input  logic [NSRC-1:0]       src_unmasked,
   input  logic [NSRC-1:0]       src_fixed,
   input  logic [NSRC-1:0]       src_lp_en,
   output logic                  wake
);
   if (NSRC < 1) begin : g_bad_nsrc
      $error("lpwr_wake_qual: NSRC must be at least 1");
   end

   logic [NSRC-1:0] src_ok;
   logic            stop_md;

   assign stop_md = (mode == MD_STOP);

   for (genvar i = 0; i < NSRC; i++) begin : g_src
      logic [LVL_W-1:0] lvl_i;
      logic             above;
      logic             kind_ok;
      assign lvl_i     = src_lvl[i*LVL_W +: LVL_W];
      assign above     = (lvl_i > thr);
      assign kind_ok   = src_fixed[i] | (~stop_md & src_lp_en[i]);
      assign src_ok[i] = src_unmasked[i] & above & kind_ok;
   end

   assign wake = |src_ok;

   AST_STOP_FIXED_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_md && wake) |-> |(src_unmasked & src_fixed)) else $error("stop wake by programmable source"); // R7
   AST_MASKED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (src_unmasked == '0) |-> !wake) else $error("wake with all sources masked"); // R9
endmodule

// File: rtl/lpwr_fsm.sv
module lpwr_fsm
   import lpwr_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      core_stop,
   input  logic      stop_en,
   input  logic [1:0] mode_sel,
   input  logic      wake,
   input  logic      core_ack,
   output lp_state_e state,
   output lp_mode_e  mode,
   output logic      clk_en,
   output logic      exit_req
);
   lp_state_e state_q;
   lp_mode_e  mode_q;
   lp_mode_e  target;
   logic      clk_en_q;
   logic      exit_q;
   logic      accept;

   always_comb begin
      if (stop_en)
         target = MD_STOP;
      else if (mode_sel == MD_DOZE || mode_sel == MD_WAIT)
         target = lp_mode_e'(mode_sel);
      else
         target = MD_NONE;
   end

   assign accept = (state_q == ST_RUN) && core_stop && (target != MD_NONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_RUN;
         mode_q   <= MD_NONE;
         clk_en_q <= 1'b1;
         exit_q   <= 1'b0;
      end else begin
         unique case (state_q)
            ST_RUN: begin
               if (accept) begin
                  state_q <= ST_ENTER;
                  mode_q  <= target;
               end
            end
            ST_ENTER: begin
               state_q  <= ST_LOWP;
               clk_en_q <= 1'b0;
            end
            ST_LOWP: begin
               if (wake) begin
                  state_q <= ST_EXIT;
                  exit_q  <= 1'b1;
               end
            end
            ST_EXIT: begin
               clk_en_q <= 1'b1;
               if (core_ack && clk_en_q) begin
                  state_q <= ST_RUN;
                  exit_q  <= 1'b0;
                  mode_q  <= MD_NONE;
               end
            end
            default: state_q <= ST_RUN;
         endcase
      end
   end

   assign state    = state_q;
   assign mode     = mode_q;
   assign clk_en   = clk_en_q;
   assign exit_req = exit_q;

   AST_CLK_OFF_IN_LOWP: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_LOWP) |-> !clk_en_q) else $error("clock on while asleep"); // R4
   AST_EXIT_NEEDS_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_LOWP && !wake) |=> !exit_q) else $error("exit without wake"); // R10
   AST_CLK_AFTER_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(clk_en_q) |-> $past(exit_q)) else $error("clock back before exit request"); // R10
   AST_NO_TARGET_STAY: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_RUN && core_stop && !stop_en && mode_sel != 2'b01 && mode_sel != 2'b10)
      |=> (state_q == ST_RUN)) else $error("left run with no target mode"); // R5
endmodule

// File: rtl/lpwr_seq.sv
module lpwr_seq
   import lpwr_pkg::*;
#(
   parameter int unsigned NSRC = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  reg_wr,
   input  logic [CTRL_W-1:0]     reg_wdata,
   output logic [CTRL_W-1:0]     reg_rdata,
   input  logic                  core_stop,
   input  logic [1:0]            mode_sel,
   input  logic                  core_ack,
   input  logic [NSRC*THR_W-1:0] irq_lvl,
   input  logic [NSRC-1:0]       irq_unmasked,
   input  logic [NSRC-1:0]       irq_fixed,
   input  logic [NSRC-1:0]       irq_lp_en,
   output logic                  clk_en_core,
   output logic                  exit_req,
   output logic [1:0]            lp_mode
);
   logic             stop_en;
   logic [THR_W-1:0] thr;
   logic             wake;
   lp_state_e        state;
   lp_mode_e         mode;

   lpwr_ctrl_reg #(
      .REG_W  (CTRL_W),
      .LVL_W  (THR_W),
      .EN_POS (STOP_EN_POS),
      .LVL_LSB(THR_LSB)
   ) u_reg (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_allow(state == ST_RUN),
      .wr_en   (reg_wr),
      .wdata   (reg_wdata),
      .stop_en (stop_en),
      .thr     (thr),
      .rdata   (reg_rdata)
   );

   lpwr_wake_qual #(
      .NSRC (NSRC),
      .LVL_W(THR_W)
   ) u_wake (
      .clk         (clk),
      .rst_n       (rst_n),
      .mode        (mode),
      .thr         (thr),
      .src_lvl     (irq_lvl),
      .src_unmasked(irq_unmasked),
      .src_fixed   (irq_fixed),
      .src_lp_en   (irq_lp_en),
      .wake        (wake)
   );

   lpwr_fsm u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .core_stop(core_stop),
      .stop_en  (stop_en),
      .mode_sel (mode_sel),
      .wake     (wake),
      .core_ack (core_ack),
      .state    (state),
      .mode     (mode),
      .clk_en   (clk_en_core),
      .exit_req (exit_req)
   );

   assign lp_mode = mode;

   AST_STOP_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      (lp_mode == MD_STOP && $past(lp_mode) == MD_NONE) |-> $past(stop_en)) else $error("stop without enable"); // R4
endmodule

// File: tb/lpwr_seq_tb_top.sv
`timescale 1ns/1ps
module lpwr_seq_tb_top;
   localparam int NSRC = 4;
   localparam time CLK_PER = 4ns;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              reg_wr = 1'b0;
   logic [7:0]        reg_wdata = '0;
   logic [7:0]        reg_rdata;
   logic              core_stop = 1'b0;
   logic [1:0]        mode_sel = 2'b00;
   logic              core_ack = 1'b0;
   logic [NSRC*3-1:0] irq_lvl = '0;
   logic [NSRC-1:0]   irq_unmasked = '0;
   logic [NSRC-1:0]   irq_fixed = '0;
   logic [NSRC-1:0]   irq_lp_en = '0;
   logic              clk_en_core;
   logic              exit_req;
   logic [1:0]        lp_mode;

   always #(CLK_PER/2) clk = ~clk;

   lpwr_seq #(.NSRC(NSRC)) dut_i (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .core_stop(core_stop), .mode_sel(mode_sel),
      .core_ack(core_ack), .irq_lvl(irq_lvl), .irq_unmasked(irq_unmasked),
      .irq_fixed(irq_fixed), .irq_lp_en(irq_lp_en), .clk_en_core(clk_en_core),
      .exit_req(exit_req), .lp_mode(lp_mode)
   );

   typedef struct {
      int unsigned due;
      logic        ce;
      logic        ex;
      logic [1:0]  md;
      logic [7:0]  rd;
      bit          ckrd;
      string       tag;
   } exp_t;

   exp_t        sbq[$];
   int unsigned cyc = 0;
   int          n_run = 0;
   int          n_fail = 0;
   bit          finished = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic push(int k, logic ce, logic ex, logic [1:0] md, logic [7:0] rd, bit ckrd, string tag);
      exp_t e;
      e.due = cyc + k; e.ce = ce; e.ex = ex; e.md = md; e.rd = rd; e.ckrd = ckrd; e.tag = tag;
      sbq.push_back(e);
   endtask

   // monitor: compares items whose due cycle has come, 1 ns after the edge
   always @(posedge clk) begin
      #1;
      for (int i = 0; i < sbq.size(); ) begin
         if (sbq[i].due <= cyc) begin
            n_run++;
            if (sbq[i].due != cyc || clk_en_core !== sbq[i].ce || exit_req !== sbq[i].ex ||
                lp_mode !== sbq[i].md || (sbq[i].ckrd && reg_rdata !== sbq[i].rd)) begin
               n_fail++;
               $display("FAIL %s: got clk_en=%b exit=%b mode=%b rdata=%h, expected clk_en=%b exit=%b mode=%b rdata=%h",
                        sbq[i].tag, clk_en_core, exit_req, lp_mode, reg_rdata,
                        sbq[i].ce, sbq[i].ex, sbq[i].md, sbq[i].rd);
            end
            sbq.delete(i);
         end else begin
            i++;
         end
      end
   end

   task automatic report();
      if (!finished) begin
         finished = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   endtask

   task automatic tick(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(logic [7:0] d, logic [7:0] exp_rd, logic ce, logic [1:0] md, string tag);
      reg_wr = 1'b1; reg_wdata = d;
      push(1, ce, 1'b0, md, exp_rd, 1'b1, tag);
      tick(1);
      reg_wr = 1'b0;
   endtask

   // source 0 programmable, source 1 fixed
   task automatic set_src(int s, logic [2:0] lvl, logic unm, logic fx, logic lpe);
      irq_lvl[s*3 +: 3] = lvl;
      irq_unmasked[s]   = unm;
      irq_fixed[s]      = fx;
      irq_lp_en[s]      = lpe;
   endtask

   task automatic clear_src();
      irq_lvl = '0; irq_unmasked = '0; irq_fixed = '0; irq_lp_en = '0;
   endtask

   initial begin
      #(CLK_PER * 200000);
      n_fail++;
      $display("FAIL watchdog: got run still active, expected completion");
      report();
   end

   initial begin
      tick(2);
      push(1, 1'b1, 1'b0, 2'b00, 8'h00, 1'b1, "R1");
      tick(1);
      rst_n = 1'b1;
      push(1, 1'b1, 1'b0, 2'b00, 8'h00, 1'b1, "R1");
      tick(1);

      // R2 register layout, reserved bits read zero
      wr(8'h5F, 8'h50, 1'b1, 2'b00, "R2");
      wr(8'hA7, 8'hA0, 1'b1, 2'b00, "R2");

      // R4 stop entry
      core_stop = 1'b1;
      push(1, 1'b1, 1'b0, 2'b11, 8'hA0, 1'b1, "R4");
      push(2, 1'b0, 1'b0, 2'b11, 8'hA0, 1'b1, "R4");
      tick(1);
      core_stop = 1'b0;
      tick(1);

      // R3 write while asleep ignored
      wr(8'h00, 8'hA0, 1'b0, 2'b11, "R3");

      // R7 programmable source in stop
      set_src(0, 3'd7, 1'b1, 1'b0, 1'b1);
      push(1, 1'b0, 1'b0, 2'b11, 8'hA0, 1'b0, "R7");
      push(2, 1'b0, 1'b0, 2'b11, 8'hA0, 1'b0, "R7");
      tick(2);
      clear_src();

      // R6 equal level does not wake
      set_src(1, 3'd2, 1'b1, 1'b1, 1'b0);
      push(1, 1'b0, 1'b0, 2'b11, 8'hA0, 1'b0, "R6");
      push(2, 1'b0, 1'b0, 2'b11, 8'hA0, 1'b0, "R6");
      tick(2);
      // R9 masked source
      set_src(1, 3'd7, 1'b0, 1'b1, 1'b1);
      push(1, 1'b0, 1'b0, 2'b11, 8'hA0, 1'b0, "R9");
      push(2, 1'b0, 1'b0, 2'b11, 8'hA0, 1'b0, "R9");
      tick(2);

      // R6/R10 fixed level above threshold wakes
      set_src(1, 3'd3, 1'b1, 1'b1, 1'b0);
      push(1, 1'b0, 1'b1, 2'b11, 8'hA0, 1'b0, "R6");
      push(2, 1'b1, 1'b1, 2'b11, 8'hA0, 1'b0, "R10");
      push(3, 1'b1, 1'b1, 2'b11, 8'hA0, 1'b0, "R10");
      tick(3);
      core_ack = 1'b1;
      push(1, 1'b1, 1'b0, 2'b00, 8'hA0, 1'b1, "R10");
      tick(1);
      core_ack = 1'b0;
      clear_src();

      // doze
      wr(8'h10, 8'h10, 1'b1, 2'b00, "R2");
      mode_sel = 2'b01; core_stop = 1'b1;
      push(1, 1'b1, 1'b0, 2'b01, 8'h10, 1'b1, "R5");
      push(2, 1'b0, 1'b0, 2'b01, 8'h10, 1'b1, "R5");
      tick(1);
      core_stop = 1'b0;
      tick(1);
      set_src(0, 3'd4, 1'b1, 1'b0, 1'b0);
      push(1, 1'b0, 1'b0, 2'b01, 8'h10, 1'b0, "R8");
      push(2, 1'b0, 1'b0, 2'b01, 8'h10, 1'b0, "R8");
      tick(2);
      irq_lp_en[0] = 1'b1;
      push(1, 1'b0, 1'b1, 2'b01, 8'h10, 1'b0, "R8");
      push(2, 1'b1, 1'b1, 2'b01, 8'h10, 1'b0, "R10");
      tick(2);
      core_ack = 1'b1;
      push(1, 1'b1, 1'b0, 2'b00, 8'h10, 1'b0, "R10");
      tick(1);
      core_ack = 1'b0;
      clear_src();

      // wait, fixed source without low-power enable
      mode_sel = 2'b10; core_stop = 1'b1;
      push(1, 1'b1, 1'b0, 2'b10, 8'h10, 1'b1, "R5");
      push(2, 1'b0, 1'b0, 2'b10, 8'h10, 1'b1, "R5");
      tick(1);
      core_stop = 1'b0;
      tick(1);
      set_src(1, 3'd2, 1'b1, 1'b1, 1'b0);
      push(1, 1'b0, 1'b1, 2'b10, 8'h10, 1'b0, "R8");
      push(2, 1'b1, 1'b1, 2'b10, 8'h10, 1'b0, "R8");
      tick(2);
      core_ack = 1'b1;
      push(1, 1'b1, 1'b0, 2'b00, 8'h10, 1'b0, "R10");
      tick(1);
      core_ack = 1'b0;
      clear_src();

      // R5 no target mode: stay running
      mode_sel = 2'b00; core_stop = 1'b1;
      push(1, 1'b1, 1'b0, 2'b00, 8'h10, 1'b1, "R5");
      push(2, 1'b1, 1'b0, 2'b00, 8'h10, 1'b1, "R5");
      tick(2);
      mode_sel = 2'b11;
      push(1, 1'b1, 1'b0, 2'b00, 8'h10, 1'b1, "R5");
      push(2, 1'b1, 1'b0, 2'b00, 8'h10, 1'b1, "R5");
      tick(2);
      core_stop = 1'b0; mode_sel = 2'b00;

      wr(8'hFF, 8'hF0, 1'b1, 2'b00, "R2");
      tick(4);
      if (sbq.size() != 0) begin
         n_fail++;
         $display("FAIL scoreboard: got %0d pending items, expected 0", sbq.size());
      end
      report();
   end
endmodule